// File: doc/BRIEF.md
# Banked Processor Register File

This block holds the general-purpose register state of a 32-bit processor core that runs in several privilege modes. Sixteen registers are visible at any time; register 15 is the program counter. Behind them sits a set of shadow copies: each exception mode keeps a private stack pointer (R13), link register (R14) and saved-status word. The fast-interrupt mode also keeps private R8 to R12.

A mode switch request carries a new mode code. On the clock edge that accepts it, the block stores the live banked registers of the mode being left into that mode's shadow slots. It then copies the entering mode's shadow slots into the live registers. The mode field of the current-status word changes in the same edge.

Two combinational read ports and one write port serve the datapath. A separate port writes the current or the saved status word. Reset clears every register and shadow copy, puts both status words in system mode, and loads a supplied start address into R15 and into a fetch pointer. Instruction decode, the ALU and memory access sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it is released, with no other activity, every general register reads 0 except R15, which reads `start_addr`. `fetch_ptr` equals `start_addr`. `cur_stat` and `sav_stat` both read 0x0000001F. `mode_prev` reads 0x1F.
- R2: Read ports return the addressed live register combinationally. A write with `wr_en` high is visible from the next clock edge. A write to register 15 also loads `fetch_ptr`.
- R3: User mode (0x10) and system mode (0x1F) share one R13/R14 pair. Switching between them leaves R13 and R14 unchanged.
- R4: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each keep a private R13/R14. The values are retained while another mode runs and reappear on return.
- R5: Fast-interrupt mode (0x11) keeps private R8 to R14. After leaving it, R8 to R12 again hold the values they had before it was entered.
- R6: Each of the modes 0x11, 0x12, 0x13, 0x17 and 0x1B has a private saved-status word, which appears on `sav_stat` after that mode is entered. A saved-status write (`stat_wr_en` high, `stat_wr_sel`=1) is ignored in user or system mode.
- R7: A switch writes only bits [4:0] of `mode_req` into `cur_stat[4:0]`; the upper request bits are ignored. After the switch, `mode_prev` holds the mode code that was active before it.
- R8: A switch to a code outside the seven listed modes changes only `cur_stat[4:0]`. No shadow copy is stored or loaded, so the live registers keep their values. A switch away from such a code stores nothing and loads the entering mode's shadow copies.
- R9: A register write in the same cycle as a mode switch lands in the live register of the entering mode. It takes priority over the value loaded from the shadow copy.
- R10: A current-status write (`stat_wr_en` high, `stat_wr_sel`=0) updates `cur_stat[31:5]` and keeps the mode field.
- R11: A switch into the mode already active changes no register. This includes fast-interrupt to fast-interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_addr | input | 32 | Value loaded into R15 and fetch pointer at reset |
| rd_a_sel | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| mode_sw | input | 1 | Mode switch request |
| mode_req | input | 8 | Requested mode; low 5 bits used |
| mode_prev | output | 5 | Mode code active before the last switch |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_sel | input | 1 | 0 = current status, 1 = saved status |
| stat_wdata | input | 32 | Status write data |
| cur_stat | output | 32 | Current status word, mode in [4:0] |
| sav_stat | output | 32 | Live saved-status word |
| fetch_ptr | output | 32 | Fetch pointer |

## Verification
The hardest state to reach is a shadow slot that must still hold a value written several mode changes earlier. The shadow copies are never visible at the ports. A value only shows up again when the owning mode is re-entered. The stimulus table therefore plants distinct values in R8, R13 and R14 in user, fast-interrupt, supervisor and interrupt modes. It then walks a mode sequence that leaves and re-enters each mode at least once, and reads the live register back at every step. Directed tests then cover the unrecognised code, repeated entry into the same mode, and saved-status handling.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int MODE_W = 5;
    localparam int NBANK  = 6;

    localparam logic [MODE_W-1:0] M_USR = 5'h10;
    localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] M_SVC = 5'h13;
    localparam logic [MODE_W-1:0] M_ABT = 5'h17;
    localparam logic [MODE_W-1:0] M_UND = 5'h1B;
    localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_USR  = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5,
        BK_NONE = 3'd6
    } bank_e;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_USR, M_SYS: return BK_USR;
            M_FIQ:        return BK_FIQ;
            M_IRQ:        return BK_IRQ;
            M_SVC:        return BK_SVC;
            M_ABT:        return BK_ABT;
            M_UND:        return BK_UND;
            default:      return BK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output bank_e             bank,
    output logic              known,
    output logic              has_sr,
    output logic              is_fast
);
    always_comb begin
        bank    = bank_of(code);
        known   = (bank != BK_NONE);
        has_sr  = known && (bank != BK_USR);
        is_fast = (bank == BK_FIQ);
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DW = 32,
    parameter int NR = 16,
    parameter int AW = $clog2(NR)
) (
    input  logic [NR-1:0][DW-1:0] regs,
    input  logic [AW-1:0]         sel,
    output logic [DW-1:0]         data
);
    always_comb data = regs[sel];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DW      = 32,
    parameter int NREG    = 16,
    parameter int REQ_W   = 8,
    parameter int HI_BASE = 8,
    parameter int NHI     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DW-1:0]            start_addr,
    input  logic [$clog2(NREG)-1:0]  rd_a_sel,
    output logic [DW-1:0]            rd_a_data,
    input  logic [$clog2(NREG)-1:0]  rd_b_sel,
    output logic [DW-1:0]            rd_b_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     mode_sw,
    input  logic [REQ_W-1:0]         mode_req,
    output logic [MODE_W-1:0]        mode_prev,
    input  logic                     stat_wr_en,
    input  logic                     stat_wr_sel,
    input  logic [DW-1:0]            stat_wdata,
    output logic [DW-1:0]            cur_stat,
    output logic [DW-1:0]            sav_stat,
    output logic [DW-1:0]            fetch_ptr
);
    localparam int AW     = $clog2(NREG);
    localparam int SP_IDX = NREG - 3;
    localparam int LR_IDX = NREG - 2;
    localparam int PC_IDX = NREG - 1;
    localparam int NPORT  = 2;
    localparam logic [DW-1:0] SR_RESET = DW'(M_SYS);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0]  gpr;
        logic [NBANK-1:0][DW-1:0] sp_bk;
        logic [NBANK-1:0][DW-1:0] lr_bk;
        logic [NBANK-1:0][DW-1:0] sr_bk;
        logic [NHI-1:0][DW-1:0]   hi_bk;
        logic [DW-1:0]            cur_sr;
        logic [DW-1:0]            sav_sr;
        logic [DW-1:0]            fetch;
        logic [MODE_W-1:0]        prev;
    } rf_state_t;

    rf_state_t st_q, st_d;

    bank_e old_bk, new_bk;
    logic  old_known, old_sr, old_fast;
    logic  new_known, new_sr, new_fast;

    rf_mode_decode i_dec_old (
        .code    (st_q.cur_sr[MODE_W-1:0]),
        .bank    (old_bk),
        .known   (old_known),
        .has_sr  (old_sr),
        .is_fast (old_fast)
    );

    rf_mode_decode i_dec_new (
        .code    (mode_req[MODE_W-1:0]),
        .bank    (new_bk),
        .known   (new_known),
        .has_sr  (new_sr),
        .is_fast (new_fast)
    );

    logic [NPORT-1:0][AW-1:0] rd_sel;
    logic [NPORT-1:0][DW-1:0] rd_data;

    assign rd_sel[0] = rd_a_sel;
    assign rd_sel[1] = rd_b_sel;

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        rf_read_port #(.DW(DW), .NR(NREG), .AW(AW)) i_port (
            .regs (st_q.gpr),
            .sel  (rd_sel[g]),
            .data (rd_data[g])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    logic eff_sr;
    logic do_bank;

    always_comb begin
        st_d    = st_q;
        eff_sr  = mode_sw ? new_sr : old_sr;
        do_bank = mode_sw && new_known && (old_bk != new_bk);

        if (mode_sw) begin
            st_d.prev = st_q.cur_sr[MODE_W-1:0];
            st_d.cur_sr[MODE_W-1:0] = mode_req[MODE_W-1:0];
        end

        if (do_bank) begin
            // store the outgoing mode
            if (old_known) begin
                st_d.sp_bk[old_bk] = st_q.gpr[SP_IDX];
                st_d.lr_bk[old_bk] = st_q.gpr[LR_IDX];
                if (old_sr) st_d.sr_bk[old_bk] = st_q.sav_sr;
            end
            // load the incoming mode (its slots differ from the outgoing ones)
            st_d.gpr[SP_IDX] = st_q.sp_bk[new_bk];
            st_d.gpr[LR_IDX] = st_q.lr_bk[new_bk];
            if (new_sr) st_d.sav_sr = st_q.sr_bk[new_bk];
            // at most one side is fast-interrupt here: one exchange
            if (old_fast || new_fast) begin
                for (int i = 0; i < NHI; i++) begin
                    st_d.gpr[HI_BASE+i] = st_q.hi_bk[i];
                    st_d.hi_bk[i]       = st_q.gpr[HI_BASE+i];
                end
            end
        end

        if (wr_en) begin
            st_d.gpr[wr_sel] = wr_data;
            if (wr_sel == AW'(PC_IDX)) st_d.fetch = wr_data;
        end

        if (stat_wr_en) begin
            if (!stat_wr_sel)
                st_d.cur_sr[DW-1:MODE_W] = stat_wdata[DW-1:MODE_W];
            else if (eff_sr)
                st_d.sav_sr = stat_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.gpr[PC_IDX] <= start_addr;
            st_q.fetch       <= start_addr;
            st_q.cur_sr      <= SR_RESET;
            st_q.sav_sr      <= SR_RESET;
            st_q.prev        <= M_SYS;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_stat  = st_q.cur_sr;
    assign sav_stat  = st_q.sav_sr;
    assign fetch_ptr = st_q.fetch;
    assign mode_prev = st_q.prev;

endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int REQ_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     rd_a_sel,
    input logic [DW-1:0]     rd_a_data,
    input logic              wr_en,
    input logic [AW-1:0]     wr_sel,
    input logic [DW-1:0]     wr_data,
    input logic              mode_sw,
    input logic [REQ_W-1:0]  mode_req,
    input logic [MODE_W-1:0] mode_prev,
    input logic              stat_wr_en,
    input logic              stat_wr_sel,
    input logic [DW-1:0]     cur_stat,
    input logic [DW-1:0]     sav_stat,
    input logic [DW-1:0]     fetch_ptr
);
    p_mode_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw |=> cur_stat[MODE_W-1:0] == $past(mode_req[MODE_W-1:0]));

    p_prev_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw |=> mode_prev == $past(cur_stat[MODE_W-1:0]));

    p_write_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_a_sel != $past(wr_sel)) || (rd_a_data == $past(wr_data)));

    p_fetch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '1) |=> fetch_ptr == $past(wr_data));

    p_cur_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sw && !stat_wr_en) |=> $stable(cur_stat));

    p_sav_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && stat_wr_sel && !mode_sw &&
         (cur_stat[MODE_W-1:0] == M_USR || cur_stat[MODE_W-1:0] == M_SYS))
        |=> $stable(sav_stat));
endmodule

bind banked_regfile rf_checker #(.DW(DW), .AW($clog2(NREG)), .REQ_W(REQ_W)) i_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] START = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, stat_wdata = '0;
    logic        wr_en = 1'b0, mode_sw = 1'b0, stat_wr_en = 1'b0, stat_wr_sel = 1'b0;
    logic [7:0]  mode_req = '0;
    logic [4:0]  mode_prev;
    logic [31:0] cur_stat, sav_stat, fetch_ptr;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .start_addr(START),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_sw(mode_sw), .mode_req(mode_req), .mode_prev(mode_prev),
        .stat_wr_en(stat_wr_en), .stat_wr_sel(stat_wr_sel), .stat_wdata(stat_wdata),
        .cur_stat(cur_stat), .sav_stat(sav_stat), .fetch_ptr(fetch_ptr)
    );

    typedef struct packed {
        logic        sw;
        logic [7:0]  mode;
        logic        we;
        logic [3:0]  wsel;
        logic [31:0] wdata;
        logic [3:0]  csel;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h00, 1'b1, 4'd13, 32'h0000_1111, 4'd13, 32'h0000_1111}, // R2
        '{1'b0, 8'h00, 1'b1, 4'd8,  32'h0000_0808, 4'd8,  32'h0000_0808}, // R2
        '{1'b1, 8'h11, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0},         // R5 enter fast
        '{1'b0, 8'h00, 1'b1, 4'd8,  32'h0000_F8F8, 4'd8,  32'h0000_F8F8}, // R5
        '{1'b0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0},         // R5 private R13
        '{1'b1, 8'h10, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_0808}, // R5 restore
        '{1'b0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_1111}, // R3
        '{1'b1, 8'hFF, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_1111}, // R3 R7 user->system
        '{1'b1, 8'h13, 1'b1, 4'd13, 32'h0000_5353, 4'd13, 32'h0000_5353}, // R9
        '{1'b1, 8'h12, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0},         // R4
        '{1'b0, 8'h00, 1'b1, 4'd14, 32'h0000_1414, 4'd14, 32'h0000_1414}, // R4
        '{1'b1, 8'h13, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_5353}, // R4 R9 retained
        '{1'b1, 8'h11, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_F8F8}, // R5 re-enter
        '{1'b1, 8'h1F, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0},         // R3 shared R14
        '{1'b1, 8'h12, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_1414}  // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus, then release controls at the next falling edge
    task automatic cyc(input logic sw, input logic [7:0] m, input logic we,
                       input logic [3:0] ws, input logic [31:0] wd);
        @(negedge clk);
        mode_sw = sw; mode_req = m; wr_en = we; wr_sel = ws; wr_data = wd;
        @(negedge clk);
        mode_sw = 1'b0; wr_en = 1'b0; stat_wr_en = 1'b0;
    endtask

    task automatic stat_wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        stat_wr_en = 1'b1; stat_wr_sel = sel; stat_wdata = d;
        @(negedge clk);
        stat_wr_en = 1'b0;
    endtask

    task automatic rd_a(input string tag, input logic [3:0] s, input logic [31:0] exp);
        rd_a_sel = s;
        #1;
        check(tag, rd_a_data, exp);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked during and after reset
        rd_a("R1 r0 in reset", 4'd0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_a("R1 r15", 4'd15, START);
        rd_a("R1 r13", 4'd13, 32'h0);
        check("R1 fetch", fetch_ptr, START);
        check("R1 cur_stat", cur_stat, 32'h1F);
        check("R1 sav_stat", sav_stat, 32'h1F);
        check("R1 mode_prev", {27'h0, mode_prev}, 32'h1F);

        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i].sw, VEC[i].mode, VEC[i].we, VEC[i].wsel, VEC[i].wdata);
            rd_a($sformatf("vector %0d (R2-R5,R9)", i), VEC[i].csel, VEC[i].exp);
        end

        // R7: previous mode and mode field after system -> interrupt
        check("R7 mode_prev", {27'h0, mode_prev}, 32'h1F);
        check("R7 mode field", {27'h0, cur_stat[4:0]}, 32'h12);

        // R6 saved status per mode
        stat_wr(1'b1, 32'hA000_0012);
        check("R6 sav write in irq", sav_stat, 32'hA000_0012);
        cyc(1'b1, 8'h13, 1'b0, 4'd0, 32'h0);
        check("R6 svc sav_stat", sav_stat, 32'h0);
        cyc(1'b1, 8'h12, 1'b0, 4'd0, 32'h0);
        check("R6 irq sav_stat back", sav_stat, 32'hA000_0012);
        cyc(1'b1, 8'h10, 1'b0, 4'd0, 32'h0);
        stat_wr(1'b1, 32'h0000_0055);
        check("R6 sav write ignored in user", sav_stat, 32'hA000_0012);

        // R10 current status write keeps mode field
        stat_wr(1'b0, 32'hF000_0000);
        check("R10 cur_stat", cur_stat, 32'hF000_0010);

        // R8 unrecognised code
        cyc(1'b1, 8'h13, 1'b0, 4'd0, 32'h0);
        rd_a("R8 svc r13 before", 4'd13, 32'h0000_5353);
        cyc(1'b0, 8'h00, 1'b1, 4'd13, 32'h0000_AAAA);
        cyc(1'b1, 8'h05, 1'b0, 4'd0, 32'h0);
        rd_a("R8 r13 kept on unknown", 4'd13, 32'h0000_AAAA);
        check("R8 mode field", {27'h0, cur_stat[4:0]}, 32'h05);
        cyc(1'b1, 8'h13, 1'b0, 4'd0, 32'h0);
        rd_a("R8 svc bank untouched", 4'd13, 32'h0000_5353);

        // R11 re-entering the same mode
        cyc(1'b1, 8'h13, 1'b0, 4'd0, 32'h0);
        rd_a("R11 svc->svc r13", 4'd13, 32'h0000_5353);
        cyc(1'b1, 8'h11, 1'b0, 4'd0, 32'h0);
        rd_a("R11 fast r8", 4'd8, 32'h0000_F8F8);
        cyc(1'b1, 8'h11, 1'b0, 4'd0, 32'h0);
        rd_a("R11 fast->fast r8", 4'd8, 32'h0000_F8F8);
        cyc(1'b1, 8'h10, 1'b0, 4'd0, 32'h0);
        rd_a("R5 user r8 after fast", 4'd8, 32'h0000_0808);

        // R2 program counter write also moves fetch pointer
        cyc(1'b0, 8'h00, 1'b1, 4'd15, 32'h0000_0100);
        rd_b_sel = 4'd15;
        #1;
        check("R2 r15 port b", rd_b_data, 32'h0000_0100);
        check("R2 fetch_ptr", fetch_ptr, 32'h0000_0100);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule